// File: doc/BRIEF.md
# Configurable serial character transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. Each frame has a low start bit, five to eight data bits sent least-significant bit first, an optional parity bit, and a high stop period of one, one and a half or two bit times. A small line-control word sets the frame format. It consists of a 2-bit word-length select, a parity enable, an even-parity select and a stop-length select.

Characters arrive through a valid/ready handshake. Bit timing comes from an external enable pulse that runs at sixteen times the bit rate. The block samples the line-control word at the moment it accepts a character, so software or a neighbouring block may change the control inputs while a frame is on the line without corrupting that frame.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset the line output is high and the block is ready. Whenever the block is ready the line is high.
- R2: A character is accepted on a clock edge where in_valid and in_ready are both high. in_ready is low from the next cycle until the final stop tick has been consumed, and it is high again in the cycle after that tick.
- R3: The start bit drives the line low from the cycle after acceptance, and it lasts for 16 baud ticks.
- R4: word_sel selects the data length: 2'b00 gives 5 bits, 2'b01 gives 6, 2'b10 gives 7 and 2'b11 gives 8. Data bits follow the start bit, least-significant bit first, and each lasts 16 ticks.
- R5: in_data bits at or above the selected length never reach the line and do not affect parity.
- R6: When par_en is high, one parity bit of 16 ticks follows the last data bit. With par_even low, the data bits plus the parity bit hold an odd number of ones. With par_even high, that count is even.
- R7: When par_en is low, no parity bit is sent and par_even has no effect on the line.
- R8: The stop period is high. With stop_sel low it lasts 16 ticks. With stop_sel high it lasts 32 ticks for 6-, 7- and 8-bit characters and 24 ticks for 5-bit characters.
- R9: The line-control inputs are captured on the acceptance edge. Changing them during a frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick16 | input | 1 | Baud enable, one clock wide, at 16x the bit rate |
| word_sel | input | 2 | Data length select (5 to 8 bits) |
| par_en | input | 1 | Parity bit enable |
| par_even | input | 1 | Even parity when high, odd parity when low |
| stop_sel | input | 1 | Long stop period when high |
| in_valid | input | 1 | Character offered |
| in_data | input | 8 | Character; only the low selected bits are used |
| in_ready | output | 1 | Block can accept a character |
| txd | output | 1 | Serial line output |

## Verification
The assertions assume that tick16 is a pulse one clock wide, so the bit timer advances by at most one per cycle. They also assume that reset is held for several cycles before the first handshake. The stimulus generates tick16 from a divider that is high for one cycle out of two, and it holds rst_n low for several edges. After each acceptance, the bench deliberately drives the control inputs to other values. Both the frame checks and the configuration-hold assertion therefore rely only on the captured copy.

// File: rtl/sftx_pkg.sv
// Shared types for the serial frame transmitter.
// Assumes: word length never exceeds 8 bits; control word fits 5 bits.
package sftx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } sftx_state_e;

    typedef struct packed {
        logic [1:0] wsel;
        logic       par_en;
        logic       par_even;
        logic       stop_sel;
    } sftx_cfg_t;

endpackage

// File: rtl/sftx_bit_timer.sv
// Counts baud ticks within the current bit period and flags its last tick.
// Assumes: tick is at most one cycle wide; limit is nonzero and is only
// raised or kept while a period runs, never lowered below the count.
module sftx_bit_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Period ends on the tick that would bring the count up to the limit.
    assign done = tick && (cnt == limit - CNT_W'(1));

    // Advance on each tick; restart on a new frame or at period end.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (clear || done) cnt <= '0;
        else if (tick)          cnt <= cnt + CNT_W'(1);
    end

    // The count never runs past the period length chosen by the sequencer.
    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < limit);

endmodule

// File: rtl/sftx_shifter.sv
// Holds the character being sent, masked to the selected length, and the
// parity bit computed from it at load time.
// Assumes: load and advance are never high in the same cycle.
module sftx_shifter #(
    parameter int DATA_W   = 8,
    parameter int MIN_BITS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wsel,
    input  logic              par_even,
    output logic              line_bit,
    output logic              par_bit
);

    logic [DATA_W-1:0] mask;
    logic [DATA_W-1:0] masked;
    logic [DATA_W-1:0] sh;
    logic              par_q;

    // Build the mask of bits that belong to the selected word length.
    always_comb begin
        for (int i = 0; i < DATA_W; i++)
            mask[i] = (i < (MIN_BITS + int'(wsel)));
    end

    assign masked = data & mask;

    // Capture the character on load and shift it right after each data bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh    <= '0;
            par_q <= 1'b0;
        end else if (load) begin
            sh    <= masked;
            par_q <= (^masked) ^ ~par_even;
        end else if (advance) begin
            sh    <= sh >> 1;
        end
    end

    assign line_bit = sh[0];
    assign par_bit  = par_q;

    // The sequencer never loads a new character while it is shifting one.
    assert_load_advance_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && advance));

endmodule

// File: rtl/serial_frame_tx.sv
// Serial character transmitter: accepts a character over valid/ready and
// sends start, data (LSB first), optional parity and stop periods.
// Assumes: tick16 is a one-cycle enable at 16x bit rate; reset is synchronous.
module serial_frame_tx
    import sftx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int OVERSAMPLE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [1:0]        word_sel,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              stop_sel,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              txd
);

    localparam int MIN_BITS   = DATA_W - 3;
    localparam int IDX_W      = $clog2(DATA_W);
    localparam int CNT_W      = $clog2(2 * OVERSAMPLE + 1);
    localparam int STOP_ONE   = OVERSAMPLE;
    localparam int STOP_HALF  = OVERSAMPLE + OVERSAMPLE / 2;
    localparam int STOP_TWO   = 2 * OVERSAMPLE;

    sftx_state_e      state;
    sftx_cfg_t        cfg_in;
    sftx_cfg_t        cfg_q;
    logic [IDX_W-1:0] bit_idx;
    logic [IDX_W-1:0] last_idx;
    logic [CNT_W-1:0] stop_ticks;
    logic [CNT_W-1:0] limit;
    logic             accept;
    logic             period_done;
    logic             data_bit;
    logic             par_bit;

    assign cfg_in   = '{wsel: word_sel, par_en: par_en, par_even: par_even,
                        stop_sel: stop_sel};
    assign in_ready = (state == ST_IDLE);
    assign accept   = in_valid && in_ready;
    assign last_idx = IDX_W'(MIN_BITS - 1) + IDX_W'(cfg_q.wsel);

    // Stop period length from the captured control word.
    always_comb begin
        if (!cfg_q.stop_sel)        stop_ticks = CNT_W'(STOP_ONE);
        else if (cfg_q.wsel == 2'b00) stop_ticks = CNT_W'(STOP_HALF);
        else                        stop_ticks = CNT_W'(STOP_TWO);
    end

    assign limit = (state == ST_STOP) ? stop_ticks : CNT_W'(OVERSAMPLE);

    sftx_bit_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick16),
        .limit (limit),
        .done  (period_done)
    );

    sftx_shifter #(.DATA_W(DATA_W), .MIN_BITS(MIN_BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .advance  ((state == ST_DATA) && period_done),
        .data     (in_data),
        .wsel     (word_sel),
        .par_even (par_even),
        .line_bit (data_bit),
        .par_bit  (par_bit)
    );

    // Frame sequencer: walks start, data, parity and stop periods.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            cfg_q   <= '{wsel: 2'b00, par_en: 1'b0, par_even: 1'b0, stop_sel: 1'b0};
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    state <= ST_START;
                    cfg_q <= cfg_in;
                end
                ST_START: if (period_done) begin
                    state   <= ST_DATA;
                    bit_idx <= '0;
                end
                ST_DATA: if (period_done) begin
                    if (bit_idx == last_idx)
                        state <= cfg_q.par_en ? ST_PARITY : ST_STOP;
                    else
                        bit_idx <= bit_idx + IDX_W'(1);
                end
                ST_PARITY: if (period_done) state <= ST_STOP;
                ST_STOP:   if (period_done) state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

    // Line level selected by the current period.
    always_comb begin
        case (state)
            ST_START:  txd = 1'b0;
            ST_DATA:   txd = data_bit;
            ST_PARITY: txd = par_bit;
            default:   txd = 1'b1;
        endcase
    end

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> txd);

    assert_accept_starts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!txd && !in_ready));

    assert_ready_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && !((state == ST_STOP) && period_done)) |=> !in_ready);

    assert_ready_returns_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_STOP) && period_done) |=> (in_ready && txd));

    assert_parity_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PARITY) |-> cfg_q.par_en);

    assert_cfg_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready && $past(!in_ready)) |-> $stable(cfg_q));

endmodule

// File: tb/sim_serial_frame_tx.sv
// Sweeps every line-control combination with several characters and checks
// the serial line tick by tick against a frame built arithmetically here.
module sim_serial_frame_tx;

    localparam int CLK_PERIOD = 10;
    localparam int OVS        = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic [1:0] word_sel = 2'b00;
    logic       par_en = 1'b0;
    logic       par_even = 1'b0;
    logic       stop_sel = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready;
    logic       txd;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    serial_frame_tx u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .word_sel(word_sel),
        .par_en(par_en), .par_even(par_even), .stop_sel(stop_sel),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .txd(txd)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Baud enable: high one cycle in two, changed just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1 tick16 = ~tick16;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Send one character and compare every tick of its frame.
    task automatic send(input logic [7:0] d, input logic [1:0] ws, input logic pe,
                        input logic ev, input logic sb);
        int n, p, stop_len, total, seg, lvl;
        logic [7:0] md;
        logic par;
        int bad_start, bad_data, bad_par, bad_stop, bad_rdy;
        int act_s, exp_s;
        n  = 5 + int'(ws);
        p  = pe ? 1 : 0;
        md = d & 8'((1 << n) - 1);
        par = (^md) ^ ~ev;
        stop_len = !sb ? OVS : (ws == 2'b00 ? OVS + OVS / 2 : 2 * OVS);
        total = OVS * (1 + n + p) + stop_len;
        bad_start = 0; bad_data = 0; bad_par = 0; bad_stop = 0; bad_rdy = 0;
        act_s = 0; exp_s = 0;

        @(negedge clk);
        word_sel = ws; par_en = pe; par_even = ev; stop_sel = sb;
        in_data = d; in_valid = 1'b1;
        @(posedge clk);
        while (!in_ready) @(posedge clk);
        // Acceptance edge has passed: withdraw and scramble control (R9).
        @(negedge clk);
        in_valid = 1'b0;
        word_sel = ~ws; par_en = ~pe; par_even = ~ev; stop_sel = ~sb;
        in_data = ~d;

        for (int k = 0; k < total; k++) begin
            if (k != 0) @(negedge clk);
            while (!tick16) begin
                if (in_ready) bad_rdy++;
                @(negedge clk);
            end
            if (in_ready) bad_rdy++;
            seg = k / OVS;
            if (seg == 0)               lvl = 0;
            else if (seg <= n)          lvl = int'(md[seg - 1]);
            else if (p == 1 && seg == n + 1) lvl = int'(par);
            else                        lvl = 1;
            if (int'(txd) != lvl) begin
                act_s = int'(txd); exp_s = lvl;
                if (seg == 0)               bad_start++;
                else if (seg <= n)          bad_data++;
                else if (p == 1 && seg == n + 1) bad_par++;
                else                        bad_stop++;
            end
        end
        @(negedge clk);
        check(bad_start == 0, "R3", "start bit level (R9 cfg hold)", act_s, exp_s);
        check(bad_data == 0, "R4/R5", "data bits LSB first, masked", act_s, exp_s);
        check(bad_par == 0, pe ? "R6" : "R7", "parity slot", act_s, exp_s);
        check(bad_stop == 0, "R8", "stop period high and length", act_s, exp_s);
        check(bad_rdy == 0, "R2", "in_ready low during frame", bad_rdy, 0);
        check(in_ready == 1'b1, "R2", "in_ready back after last stop tick",
              int'(in_ready), 1);
        check(txd == 1'b1, "R1", "line idle high after frame", int'(txd), 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready during reset", int'(in_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
        check(txd == 1'b1, "R1", "txd after reset", int'(txd), 1);

        for (int c = 0; c < 32; c++) begin
            send(8'h00, c[1:0], c[2], c[3], c[4]);
            send(8'hFF, c[1:0], c[2], c[3], c[4]);
            send(8'hA5, c[1:0], c[2], c[3], c[4]);
            send(8'h3C ^ 8'(c * 37), c[1:0], c[2], c[3], c[4]);
        end
        // Upper bits set only above 5 bits: line must see zeros (R5).
        send(8'hE0, 2'b00, 1'b1, 1'b1, 1'b0);
        send(8'h80, 2'b10, 1'b1, 1'b0, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule